// File: doc/BRIEF.md
# Channel Run-Control and Interrupt Aggregator

This block holds the run state and the interrupt bookkeeping for a set of DMA channels. The channel number fixes the direction. Even channels feed a peripheral from memory (transmit). Odd channels fill memory from a peripheral (receive). Channels are handled in pairs: pair n holds transmit channel 2n and receive channel 2n+1. Software starts and stops channels by writing one-hot words to four write-one command registers, one start and one stop register for each direction. Each channel runs a two-state machine. In `CH_STOPPED`, a start bit for the channel moves it to `CH_RUNNING`. In `CH_RUNNING`, a stop bit for the channel moves it back to `CH_STOPPED`. Any other command leaves the state as it is. The output `run_en` is high only in `CH_RUNNING`.

The ring logic raises single-cycle event pulses for each channel: one when a descriptor completes and one on an error. Each channel keeps four independent copies of a sticky status register and four mask registers, one copy per interrupt output. A status copy is cleared by writing 1 to its bits. For each output, a summary register per direction shows which pairs have a masked cause pending. The output's interrupt line is the level OR of both summaries.

All registers sit in one word-addressed space. Writes are single-cycle strobes, and reads are combinational.

Top module: `chan_irq_runctl`

## Requirements
- R1: Direction follows the channel number. Channel 2n is controlled by bit n of the transmit start register (word 0) and the transmit stop register (word 1). Channel 2n+1 is controlled by bit n of the receive start register (word 2) and the receive stop register (word 3).
- R2: Writing 1 to bit n of a start register sets `run_en` of the matching channel from the cycle after the write. Zero bits have no effect.
- R3: Writing 1 to bit n of a stop register clears `run_en` of the matching channel from the cycle after the write. Status and mask contents are left unchanged. A later start makes the channel run again.
- R4: A `evt_done[c]` pulse sets bit 0, and an `evt_err[c]` pulse sets bit 6, in all four status copies of channel c. These bits stay set until cleared.
- R5: Status copy o of channel c is at word 16+8c+o. Writing 1 to bit 0 or bit 6 clears that bit in that copy only. If an event arrives in the same cycle as the clear, the event wins.
- R6: Mask o of channel c is at word 16+8c+4+o. Only bits 0 and 6 are stored. All other bits read as 0. Masks reset to 0.
- R7: Transmit summary word 4+o has bit i set when (status copy o AND mask o) of channel 2i is nonzero. Receive summary word 8+o does the same for channel 2i+1.
- R8: `irq[o]` is high exactly while either summary word for output o is nonzero.
- R9: When mask bit 6 is clear and mask bit 0 is set, an error event does not drive the output, but a descriptor-done event still does.
- R10: After reset, all channels are stopped, all status and mask bits are 0, and all `irq` lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | ADDR_W | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_done | input | NUM_CH | Descriptor-completed pulse, one bit per channel |
| evt_err | input | NUM_CH | Error pulse, one bit per channel |
| run_en | output | NUM_CH | Channel is in the running state |
| irq | output | 4 | Level interrupt line for each output |

## Verification
The assertions assume that `reg_wr` is a single-cycle strobe carrying one address. As a result, no channel ever sees a start and a stop in the same cycle. They also assume that events are clean one-cycle pulses and that reset is held for at least one edge. The bench drives every write through a task that raises the strobe for exactly one clock and then drops it. It drives events through a separate pulse task. It overlaps a write with an event only in the deliberate same-cycle clear-versus-set case. Every command word it writes targets a single address at a time.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int NUM_OUT     = 4;
    localparam int DATA_W      = 32;
    localparam int BIT_DONE    = 0;
    localparam int BIT_ERR     = 6;
    localparam int A_TX_START  = 0;
    localparam int A_TX_STOP   = 1;
    localparam int A_RX_START  = 2;
    localparam int A_RX_STOP   = 3;
    localparam int A_TX_SUM    = 4;
    localparam int A_RX_SUM    = 8;
    localparam int A_CH_BASE   = 16;
    localparam int A_CH_STRIDE = 8;
    localparam int A_MASK_OFS  = 4;

    typedef enum logic {
        CH_STOPPED = 1'b0,
        CH_RUNNING = 1'b1
    } run_state_e;
endpackage

// File: rtl/ch_irq_slice.sv
module ch_irq_slice
    import irqagg_pkg::*;
#(
    parameter int N_OUT = NUM_OUT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_hit,
    input  logic                        stop_hit,
    input  logic                        evt_done,
    input  logic                        evt_err,
    input  logic [N_OUT-1:0]            sts_wr,
    input  logic [N_OUT-1:0]            mask_wr,
    input  logic [1:0]                  wbits,
    output logic                        run_en,
    output logic [N_OUT-1:0][1:0]       sts,
    output logic [N_OUT-1:0][1:0]       msk,
    output logic [N_OUT-1:0]            cause
);
    run_state_e state_q, state_d;
    logic [1:0] ev;

    assign ev = {evt_err, evt_done};

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOPPED: if (start_hit) state_d = CH_RUNNING;
            CH_RUNNING: if (stop_hit)  state_d = CH_STOPPED;
        endcase
    end

    always_comb run_en = (state_q == CH_RUNNING);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
            msk <= '0;
        end else begin
            for (int o = 0; o < N_OUT; o++) begin
                sts[o] <= ev | (sts[o] & ~(sts_wr[o] ? wbits : 2'b00));
                if (mask_wr[o]) msk[o] <= wbits;
            end
        end
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++) cause[o] = |(sts[o] & msk[o]);
    end

    // R2
    run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |=> run_en);
    // R3
    run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> !run_en);

    for (genvar o = 0; o < N_OUT; o++) begin : g_chk
        // R4
        done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_done |=> sts[o][0]);
        // R4
        err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_err |=> sts[o][1]);
        // R5
        w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sts_wr[o] && wbits[0] && !evt_done |=> !sts[o][0]);
        // R6
        mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mask_wr[o] |=> $stable(msk[o]));
    end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irqagg_pkg::*;
#(
    parameter int N_CH  = 8,
    parameter int N_OUT = NUM_OUT,
    localparam int PAIRS = N_CH / 2
) (
    input  logic [N_CH-1:0][N_OUT-1:0]  cause,
    output logic [N_OUT-1:0][PAIRS-1:0] tx_sum,
    output logic [N_OUT-1:0][PAIRS-1:0] rx_sum,
    output logic [N_OUT-1:0]            irq
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            assign tx_sum[o][p] = cause[2*p][o];
            assign rx_sum[o][p] = cause[2*p+1][o];
        end
        assign irq[o] = (|tx_sum[o]) | (|rx_sum[o]);
    end
endmodule

// File: rtl/chan_irq_runctl.sv
module chan_irq_runctl
    import irqagg_pkg::*;
#(
    parameter  int NUM_CH = 8,
    localparam int PAIRS  = NUM_CH / 2,
    localparam int ADDR_W = $clog2(A_CH_BASE + NUM_CH * A_CH_STRIDE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_CH-1:0]   evt_done,
    input  logic [NUM_CH-1:0]   evt_err,
    output logic [NUM_CH-1:0]   run_en,
    output logic [NUM_OUT-1:0]  irq
);
    logic wr_tx_start, wr_tx_stop, wr_rx_start, wr_rx_stop;
    logic ch_region;
    logic [ADDR_W-1:0] rel, ch_idx;
    logic [2:0] sub;
    logic [1:0] wbits;
    logic [NUM_CH-1:0][NUM_OUT-1:0][1:0] sts_all, msk_all;
    logic [NUM_CH-1:0][NUM_OUT-1:0]      cause_all;
    logic [NUM_OUT-1:0][PAIRS-1:0]       tx_sum, rx_sum;

    assign wr_tx_start = reg_wr && (reg_addr == ADDR_W'(A_TX_START));
    assign wr_tx_stop  = reg_wr && (reg_addr == ADDR_W'(A_TX_STOP));
    assign wr_rx_start = reg_wr && (reg_addr == ADDR_W'(A_RX_START));
    assign wr_rx_stop  = reg_wr && (reg_addr == ADDR_W'(A_RX_STOP));
    assign ch_region   = (reg_addr >= ADDR_W'(A_CH_BASE));
    assign rel         = reg_addr - ADDR_W'(A_CH_BASE);
    assign ch_idx      = rel >> 3;
    assign sub         = rel[2:0];
    assign wbits       = {reg_wdata[BIT_ERR], reg_wdata[BIT_DONE]};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int P = c / 2;
        logic start_hit, stop_hit;
        logic [NUM_OUT-1:0] sts_wr, mask_wr;

        if (c % 2 == 0) begin : g_tx
            assign start_hit = wr_tx_start && reg_wdata[P];
            assign stop_hit  = wr_tx_stop  && reg_wdata[P];
        end else begin : g_rx
            assign start_hit = wr_rx_start && reg_wdata[P];
            assign stop_hit  = wr_rx_stop  && reg_wdata[P];
        end

        for (genvar o = 0; o < NUM_OUT; o++) begin : g_wr
            assign sts_wr[o]  = reg_wr && ch_region && (ch_idx == ADDR_W'(c))
                                && (sub == 3'(o));
            assign mask_wr[o] = reg_wr && ch_region && (ch_idx == ADDR_W'(c))
                                && (sub == 3'(A_MASK_OFS + o));
        end

        ch_irq_slice #(.N_OUT(NUM_OUT)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_hit (start_hit),
            .stop_hit  (stop_hit),
            .evt_done  (evt_done[c]),
            .evt_err   (evt_err[c]),
            .sts_wr    (sts_wr),
            .mask_wr   (mask_wr),
            .wbits     (wbits),
            .run_en    (run_en[c]),
            .sts       (sts_all[c]),
            .msk       (msk_all[c]),
            .cause     (cause_all[c])
        );
    end

    irq_summary #(.N_CH(NUM_CH), .N_OUT(NUM_OUT)) u_sum (
        .cause  (cause_all),
        .tx_sum (tx_sum),
        .rx_sum (rx_sum),
        .irq    (irq)
    );

    always_comb begin
        logic [1:0] sel;
        reg_rdata = '0;
        sel       = '0;
        if (int'(reg_addr) >= A_TX_SUM && int'(reg_addr) < A_TX_SUM + NUM_OUT)
            reg_rdata = DATA_W'(tx_sum[reg_addr[1:0]]);
        else if (int'(reg_addr) >= A_RX_SUM && int'(reg_addr) < A_RX_SUM + NUM_OUT)
            reg_rdata = DATA_W'(rx_sum[reg_addr[1:0]]);
        else if (ch_region) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ch_idx == ADDR_W'(c))
                    sel = sub[2] ? msk_all[c][sub[1:0]] : sts_all[c][sub[1:0]];
            end
            reg_rdata[BIT_ERR]  = sel[1];
            reg_rdata[BIT_DONE] = sel[0];
        end
    end

    logic [NUM_OUT-1:0] any_cause;
    always_comb begin
        any_cause = '0;
        for (int c = 0; c < NUM_CH; c++) any_cause = any_cause | cause_all[c];
    end

    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == any_cause);
endmodule

// File: tb/chan_irq_runctl_test.sv
`timescale 1ns/1ps
module chan_irq_runctl_test;
    localparam int NCH = 8;
    localparam int AW  = $clog2(16 + NCH * 8);

    logic clk = 0, rst_n = 0, reg_wr = 0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [NCH-1:0] evt_done = '0, evt_err = '0, run_en;
    logic [3:0] irq;
    int n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;

    chan_irq_runctl #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_done(evt_done),
        .evt_err(evt_err), .run_en(run_en), .irq(irq)
    );

    function automatic int sa(int c, int o); return 16 + 8 * c + o; endfunction
    function automatic int ma(int c, int o); return 16 + 8 * c + 4 + o; endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic wr_evt(int a, logic [31:0] d, logic [NCH-1:0] dn);
        @(negedge clk);
        reg_wr = 1; reg_addr = AW'(a); reg_wdata = d; evt_done = dn;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0; evt_done = '0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 d = reg_rdata;
    endtask

    task automatic pulse(logic [NCH-1:0] dn, logic [NCH-1:0] er);
        @(negedge clk);
        evt_done = dn; evt_err = er;
        @(negedge clk);
        evt_done = '0; evt_err = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [NCH-1:0] exp_run;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10 reset state
        @(negedge clk);
        check("R10 run_en", 32'(run_en), 0);
        check("R10 irq", 32'(irq), 0);
        rd(sa(5, 3), d); check("R10 status", d, 0);
        rd(ma(5, 3), d); check("R10 mask", d, 0);

        // R1 R2 start sweeps per direction
        exp_run = '0;
        for (int n = 0; n < NCH / 2; n++) begin
            wr(0, 32'(1) << n);
            exp_run[2 * n] = 1'b1;
            check("R1 R2 tx start", 32'(run_en), 32'(exp_run));
        end
        for (int n = 0; n < NCH / 2; n++) begin
            wr(2, 32'(1) << n);
            exp_run[2 * n + 1] = 1'b1;
            check("R1 R2 rx start", 32'(run_en), 32'(exp_run));
        end
        wr(0, 0);
        check("R2 zero start no effect", 32'(run_en), 32'(exp_run));
        wr(1, 32'h5);
        exp_run[0] = 0; exp_run[4] = 0;
        check("R1 R3 tx stop", 32'(run_en), 32'(exp_run));
        wr(3, 32'h2);
        exp_run[3] = 0;
        check("R1 R3 rx stop", 32'(run_en), 32'(exp_run));

        // R3 stop keeps status and mask, start resumes
        wr(ma(2, 0), 32'h41);
        pulse(8'h04, 8'h00);
        wr(1, 32'h2);
        exp_run[2] = 0;
        check("R3 stop ch2", 32'(run_en), 32'(exp_run));
        rd(sa(2, 0), d); check("R3 status kept", d, 32'h1);
        rd(ma(2, 0), d); check("R3 mask kept", d, 32'h41);
        check("R3 irq kept", 32'(irq), 32'h1);
        wr(0, 32'h2);
        exp_run[2] = 1;
        check("R3 resume ch2", 32'(run_en), 32'(exp_run));
        wr(sa(2, 0), 32'h41);
        wr(ma(2, 0), 0);

        // R4 R7 R8 sweep over every channel and output
        for (int c = 0; c < NCH; c++) begin
            for (int o = 0; o < 4; o++) begin
                wr(ma(c, o), 32'h41);
                pulse(NCH'(1) << c, '0);
                for (int q = 0; q < 4; q++) begin
                    rd(sa(c, q), d); check("R4 done all copies", d, 32'h1);
                end
                rd((c % 2 == 0) ? 4 + o : 8 + o, d);
                check("R7 summary", d, 32'(1) << (c / 2));
                rd((c % 2 == 0) ? 8 + o : 4 + o, d);
                check("R7 other direction", d, 0);
                check("R8 irq", 32'(irq), 32'(1) << o);
                for (int q = 0; q < 4; q++) wr(sa(c, q), 32'h41);
                wr(ma(c, o), 0);
                check("R8 irq cleared", 32'(irq), 0);
            end
        end

        // R4 error bit sticky
        pulse('0, 8'h20);
        rd(sa(5, 1), d); check("R4 err bit", d, 32'h40);
        repeat (3) @(negedge clk);
        rd(sa(5, 2), d); check("R4 err sticky", d, 32'h40);
        for (int q = 0; q < 4; q++) wr(sa(5, q), 32'h40);

        // R5 clear one copy, event wins over clear
        pulse(8'h02, '0);
        wr(sa(1, 1), 32'h1);
        rd(sa(1, 1), d); check("R5 copy cleared", d, 0);
        rd(sa(1, 0), d); check("R5 other copy kept", d, 32'h1);
        wr(sa(1, 0), 32'h0);
        rd(sa(1, 0), d); check("R5 zero write no effect", d, 32'h1);
        wr_evt(sa(1, 0), 32'h1, 8'h02);
        rd(sa(1, 0), d); check("R5 event wins", d, 32'h1);

        // R9 error masked, done still drives
        wr(ma(3, 2), 32'h1);
        pulse('0, 8'h08);
        check("R9 err masked", 32'(irq), 0);
        rd(sa(3, 2), d); check("R9 err recorded", d, 32'h40);
        pulse(8'h08, '0);
        check("R9 done drives", 32'(irq), 32'h4);
        rd(10, d); check("R9 rx summary", d, 32'h2);

        // R6 mask stores only two bits
        wr(ma(6, 3), 32'hFFFF_FFFF);
        rd(ma(6, 3), d); check("R6 mask bits", d, 32'h41);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule